// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block runs one parallel I/O port of configurable width, eight pins by default. Software reaches five per-pin registers through a small register bus. Each write is a single-cycle strobe and each read returns data combinationally. The five registers hold the output latch, the direction, the pull-up enable, the slew-rate enable and the drive strength. For each pin the block drives a pad-side bundle: output value, output enable, input buffer enable, pull-up, slew and drive.

Any pin can be claimed by an alternate digital peripheral, which then supplies that pin's output value and output enable. Any pin can also be claimed by an analog function, which shuts off both the input and the output buffer. An analog claim overrides a digital claim on the same pin. Reads of the data register do not follow ownership. A pin whose direction bit is 1 returns the latch. A pin whose direction bit is 0 returns the pad input after a two-flop synchronizer, or 0 while an analog claim holds its input buffer off.

Top module: `gpio_shared_port`

## Requirements
- R1: After a synchronous reset, every direction bit, latch bit, pull-up bit and drive bit is 0 and every slew bit is 1.
- R2: Register offsets are data = 0, direction = 1, pull-up = 2, slew = 3, drive = 4. A write strobe updates the selected register at the next clock edge. Offsets 5 to 7 read as 0, and writes to them change no register.
- R3: On a pin with no claim, the pad output value equals the latch bit and the pad output enable equals the direction bit.
- R4: On a pin claimed only by the digital peripheral, the pad output value and output enable equal the peripheral's values, and the latch and direction bits have no effect on them.
- R5: A data-register read returns the latch bit for every pin whose direction bit is 1, whether or not a peripheral claims that pin.
- R6: A data-register read returns the pad input for a pin whose direction bit is 0 and that has no analog claim. A pad change present at clock edge k is visible after edge k+1.
- R7: On a pin with an analog claim, the pad output enable, the pad output value and the input buffer enable are all 0, even when the digital claim is also set.
- R8: A data-register read returns 0 for a pin whose direction bit is 0 and that has an analog claim.
- R9: Without an analog claim, the input buffer enable is 1 whatever the direction bit and the digital claim are.
- R10: A write to the data register updates the latch even while the pin is an input, so the preloaded value drives the pad as soon as the direction bit becomes 1.
- R11: The pad pull-up, slew and drive outputs equal the corresponding register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data for bus_addr |
| alt_dig_en | input | W | Per-pin digital peripheral claim |
| alt_out | input | W | Peripheral output values |
| alt_oe | input | W | Peripheral output enables |
| ana_en | input | W | Per-pin analog claim |
| pad_in | input | W | Raw pad input values |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output buffer enables |
| pad_ie | output | W | Pad input buffer enables |
| pad_pull | output | W | Pad pull-up enables |
| pad_slew | output | W | Pad slew-rate control enables |
| pad_drive | output | W | Pad high-drive selects |

## Verification
The bench goes after pins whose direction bit is 1 while a peripheral owns the output. A design that let ownership pick the read source would return pad data there instead of the latch. It sets the analog and digital claims together to catch a priority error, which would leave the peripheral driving a pad meant to float. It reads input pins under an analog claim to catch a design that leaks stale synchronizer contents instead of 0. It times pad input changes edge by edge to catch a synchronizer one stage too short or too long. It also writes the latch before turning a pin to output, writes to the unused offsets, and runs a long random phase in which every output is compared with a behavioural model on each cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PULL  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_SLEW  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_DRIVE = 3'd4;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pull_q,
  output logic [W-1:0]      slew_q,
  output logic [W-1:0]      drive_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
      slew_q  <= ALL_ONES;
      drive_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_DATA:  data_q  <= wr_data;
        OFS_DIR:   dir_q   <= wr_data;
        OFS_PULL:  pull_q  <= wr_data;
        OFS_SLEW:  slew_q  <= wr_data;
        OFS_DRIVE: drive_q <= wr_data;
        default: ;
      endcase
    end
  end

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (data_q == '0 && dir_q == '0 && pull_q == '0 &&
                    slew_q == ALL_ONES && drive_q == '0));

  assert_data_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFS_DATA) |=> data_q == $past(wr_data));

  assert_unused_offset_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > OFS_DRIVE) |=>
      ($stable(data_q) && $stable(dir_q) && $stable(pull_q) &&
       $stable(slew_q) && $stable(drive_q)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];

  assert_first_stage_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chain[0] == $past(d));

  generate
    if (STAGES > 1) begin : g_tail
      assert_last_stage_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> q == $past(chain[STAGES-2]));
    end
  endgenerate
endmodule

// File: rtl/gpio_pin_owner.sv
module gpio_pin_owner (
  input  logic latch_bit,
  input  logic dir_bit,
  input  logic alt_claim,
  input  logic alt_val,
  input  logic alt_en,
  input  logic ana_claim,
  input  logic sync_bit,
  output logic pad_val,
  output logic pad_en,
  output logic in_en,
  output logic read_bit
);
  typedef enum logic [1:0] {OWN_GPIO, OWN_ALT, OWN_ANALOG} owner_e;
  owner_e owner;

  always_comb begin
    if (ana_claim)      owner = OWN_ANALOG;
    else if (alt_claim) owner = OWN_ALT;
    else                owner = OWN_GPIO;
  end

  always_comb begin
    case (owner)
      OWN_ANALOG: begin pad_val = 1'b0;      pad_en = 1'b0;    in_en = 1'b0; end
      OWN_ALT:    begin pad_val = alt_val;   pad_en = alt_en;  in_en = 1'b1; end
      default:    begin pad_val = latch_bit; pad_en = dir_bit; in_en = 1'b1; end
    endcase
  end

  assign read_bit = dir_bit ? latch_bit : (in_en & sync_bit);
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      alt_dig_en,
  input  logic [W-1:0]      alt_out,
  input  logic [W-1:0]      alt_oe,
  input  logic [W-1:0]      ana_en,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_ie,
  output logic [W-1:0]      pad_pull,
  output logic [W-1:0]      pad_slew,
  output logic [W-1:0]      pad_drive
);
  logic [W-1:0] data_q, dir_q, pull_q, slew_q, drive_q;
  logic [W-1:0] sync_q, rd_pins;

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .slew_q(slew_q), .drive_q(drive_q)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      gpio_pin_owner u_own (
        .latch_bit(data_q[i]), .dir_bit(dir_q[i]),
        .alt_claim(alt_dig_en[i]), .alt_val(alt_out[i]), .alt_en(alt_oe[i]),
        .ana_claim(ana_en[i]), .sync_bit(sync_q[i]),
        .pad_val(pad_out[i]), .pad_en(pad_oe[i]), .in_en(pad_ie[i]),
        .read_bit(rd_pins[i])
      );
    end
  endgenerate

  assign pad_pull  = pull_q;
  assign pad_slew  = slew_q;
  assign pad_drive = drive_q;

  always_comb begin
    case (bus_addr)
      OFS_DATA:  bus_rdata = rd_pins;
      OFS_DIR:   bus_rdata = dir_q;
      OFS_PULL:  bus_rdata = pull_q;
      OFS_SLEW:  bus_rdata = slew_q;
      OFS_DRIVE: bus_rdata = drive_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_analog_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|ana_en) |-> (((pad_oe | pad_ie | pad_out) & ana_en) == '0));

  assert_alt_drives_R4: assert property (@(posedge clk) disable iff (rst)
    (((pad_out ^ alt_out) | (pad_oe ^ alt_oe)) & alt_dig_en & ~ana_en) == '0);

  assert_read_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_DATA) |-> ((bus_rdata & dir_q) == (data_q & dir_q)));

  assert_analog_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_DATA) |-> ((bus_rdata & ana_en & ~dir_q) == '0));

  assert_input_buffer_on_R9: assert property (@(posedge clk) disable iff (rst)
    (pad_ie | ana_en) == {W{1'b1}});
endmodule

// File: tb/gpio_shared_port_test.sv
module gpio_shared_port_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, bus_we;
  logic [2:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic [W-1:0] alt_dig_en, alt_out, alt_oe, ana_en, pad_in;
  logic [W-1:0] pad_out, pad_oe, pad_ie, pad_pull, pad_slew, pad_drive;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_data, m_dir, m_pull, m_slew, m_drive, m_s1, m_s2;

  gpio_shared_port #(.W(W)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .alt_dig_en(alt_dig_en), .alt_out(alt_out), .alt_oe(alt_oe),
    .ana_en(ana_en), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_pull(pad_pull), .pad_slew(pad_slew), .pad_drive(pad_drive)
  );

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_data = '0; m_dir = '0; m_pull = '0; m_slew = '1; m_drive = '0;
    m_s1 = '0; m_s2 = '0;
  endtask

  // Compare every output against the behavioural model
  task automatic compare_all();
    logic [W-1:0] eo, eoe, eie, erd;
    for (int i = 0; i < W; i++) begin
      if (ana_en[i])          begin eo[i] = 0;         eoe[i] = 0;         eie[i] = 0; end
      else if (alt_dig_en[i]) begin eo[i] = alt_out[i]; eoe[i] = alt_oe[i]; eie[i] = 1; end
      else                    begin eo[i] = m_data[i];  eoe[i] = m_dir[i];  eie[i] = 1; end
    end
    case (bus_addr)
      3'd0: for (int i = 0; i < W; i++)
              erd[i] = m_dir[i] ? m_data[i] : (ana_en[i] ? 1'b0 : m_s2[i]);
      3'd1: erd = m_dir;
      3'd2: erd = m_pull;
      3'd3: erd = m_slew;
      3'd4: erd = m_drive;
      default: erd = '0;
    endcase
    chk("R3/R4/R7", "pad_out", pad_out, eo);
    chk("R3/R4/R7", "pad_oe", pad_oe, eoe);
    chk("R7/R9", "pad_ie", pad_ie, eie);
    chk("R2/R5/R6/R8", "bus_rdata", bus_rdata, erd);
    chk("R11", "pad_pull", pad_pull, m_pull);
    chk("R11", "pad_slew", pad_slew, m_slew);
    chk("R11", "pad_drive", pad_drive, m_drive);
  endtask

  task automatic tick();
    #1 compare_all();
    @(posedge clk);
    if (rst) model_reset();
    else begin
      if (bus_we)
        case (bus_addr)
          3'd0: m_data  = bus_wdata;
          3'd1: m_dir   = bus_wdata;
          3'd2: m_pull  = bus_wdata;
          3'd3: m_slew  = bus_wdata;
          3'd4: m_drive = bus_wdata;
          default: ;
        endcase
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] v);
    bus_we = 1; bus_addr = a; bus_wdata = v;
    tick();
    bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [W-1:0] exp, string tag);
    bus_addr = a;
    #1 chk(tag, "readback", bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    alt_dig_en = 0; alt_out = 0; alt_oe = 0; ana_en = 0; pad_in = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    model_reset();
    tick();
    rst = 0;

    // R1 reset values
    rd(3'd0, 8'h00, "R1"); rd(3'd1, 8'h00, "R1"); rd(3'd2, 8'h00, "R1");
    rd(3'd3, 8'hFF, "R1"); rd(3'd4, 8'h00, "R1");
    tick();

    // R10 preload while input, then R3 drive after turning to output
    wr(3'd0, 8'h5A);
    rd(3'd0, 8'h00, "R10");
    chk("R10", "pad_oe", pad_oe, 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd0, 8'h5A, "R10");
    chk("R3", "pad_out", pad_out, 8'h5A);
    chk("R9", "pad_ie", pad_ie, 8'hFF);

    // R6 synchronizer latency on upper inputs
    wr(3'd1, 8'h0F);
    pad_in = 8'hC0;
    rd(3'd0, 8'h0A, "R6");
    tick();
    rd(3'd0, 8'h0A, "R6");
    tick();
    rd(3'd0, 8'hCA, "R6");

    // R4 / R5 peripheral owns low nibble, reads still from latch
    alt_dig_en = 8'h0F; alt_out = 8'h03; alt_oe = 8'h05;
    #1 chk("R4", "pad_out", pad_out, 8'h53);
    chk("R4", "pad_oe", pad_oe, 8'h05);
    rd(3'd0, 8'hCA, "R5");
    tick();

    // R7 / R8 analog over digital, analog input reads zero
    ana_en = 8'h81;
    #1 chk("R7", "pad_oe", pad_oe, 8'h04);
    chk("R7", "pad_ie", pad_ie, 8'h7E);
    chk("R7", "pad_out", pad_out, 8'h52);
    rd(3'd0, 8'h4A, "R8");
    tick();
    ana_en = 0; alt_dig_en = 0;
    tick();

    // R2 unused offsets: writes ignored, reads zero
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd5, 8'h00, "R2"); rd(3'd1, 8'h0F, "R2"); rd(3'd3, 8'hFF, "R2");
    rd(3'd0, 8'hCA, "R2");
    tick();

    // R11 pad control registers
    wr(3'd2, 8'h33); wr(3'd3, 8'h0F); wr(3'd4, 8'hC3);
    #1 chk("R11", "pad_pull", pad_pull, 8'h33);
    chk("R11", "pad_slew", pad_slew, 8'h0F);
    chk("R11", "pad_drive", pad_drive, 8'hC3);
    tick();

    // Random phase against the model
    for (int n = 0; n < 3000; n++) begin
      bus_we     = ($urandom % 3) == 0;
      bus_addr   = 3'($urandom);
      bus_wdata  = W'($urandom);
      alt_dig_en = W'($urandom);
      alt_out    = W'($urandom);
      alt_oe     = W'($urandom);
      ana_en     = W'($urandom) & W'($urandom);
      pad_in     = W'($urandom);
      rst        = ($urandom % 500) == 0;
      tick();
    end
    rst = 0; bus_we = 0;
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule